// File: doc/BRIEF.md
# DIMM Temperature Sensor Auto-Poller

This block is a small hardware sequencer that sits beside a bus engine shared with software. While its enable is set, it waits out a programmable interval and then asks the engine to run one temperature read on the next DIMM sensor slot that is marked present. It walks the present slots in ascending order and wraps around. When a read completes it records the slot it just visited and, on success, the returned word. A NACK from the sensor raises the same error flag that a failed software transaction raises, and no automatic poll starts while that flag is set.

Software takes the bus by clearing the enable and then waiting for the busy output to go low. A request that the engine has not yet granted is withdrawn at once. A granted poll runs to completion before busy falls. The interval comes from two counts: a shared base divider that makes a tick every `base_div+1` cycles, and a per-channel count of `poll_rate+1` ticks. Each poll either tells the engine to rewrite the sensor's register pointer first, or relies on the pointer left from an earlier write.

Top module: `dts_autopoll`

## Requirements
- R1: After reset `busy`, `eng_req` and `err_flag` are 0, and `last_slot` holds NSLOT-1, so the first poll goes to the lowest present slot.
- R2: With the enable held and the poller idle, `eng_req` rises (base_div+1)*(poll_rate+1)+1 clock edges after the first edge that samples the enable high, or after the edge that completes the previous poll.
- R3: The polled slot is the first present slot after `last_slot` in ascending order, wrapping from NSLOT-1 to 0. Absent slots are never requested. With no slot present, no request is made.
- R4: No request rises while `err_flag` is 1. An interval that expired during that time launches on the second edge after the flag clears.
- R5: While the enable is low no new request rises. A request not yet granted when the enable drops is gone after the next edge, and busy then reads 0.
- R6: `busy` is 1 from the first request cycle until the edge that samples `eng_done` of a granted poll, whatever the enable does meanwhile. It is 0 after that edge.
- R7: `last_slot` takes the polled slot on the edge that completes a granted poll, NACK or not, and does not change otherwise.
- R8: `err_flag` sets on a poll completion with `eng_nack`=1 or on `sw_nack`. It clears on `err_clr`. When a set and a clear come together, the set wins.
- R9: `eng_ptr_wr` is 1 (rewrite the pointer) when `reuse_ptr` was 0 at launch and 0 when it was 1. It and `eng_slot` stay constant from the request until completion.
- R10: A successful poll loads `eng_rdata` into `temp_word`. A NACKed poll leaves `temp_word` unchanged.
- R11: After the enable is dropped and set again, the interval restarts from zero and polling resumes at the slot after `last_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_en | input | 1 | Automatic polling enable |
| slot_present | input | NSLOT | One presence flag per sensor slot |
| reuse_ptr | input | 1 | 1: rely on the earlier pointer; 0: rewrite the pointer on every poll |
| base_div | input | DIV_W | Shared divider; a tick every base_div+1 cycles |
| poll_rate | input | RATE_W | Per-channel interval in ticks, minus one |
| sw_nack | input | 1 | A software transaction ended in NACK |
| err_clr | input | 1 | Clear the error flag |
| eng_req | output | 1 | Poll request to the shared engine |
| eng_slot | output | SLOT_W | Slot address of the requested poll |
| eng_ptr_wr | output | 1 | The poll must rewrite the sensor pointer first |
| eng_grant | input | 1 | Engine accepts the request |
| eng_done | input | 1 | Engine finished the granted poll |
| eng_nack | input | 1 | The finished poll was NACKed (valid with eng_done) |
| eng_rdata | input | DATA_W | Word read by the finished poll |
| busy | output | 1 | A poll is requested or in flight |
| last_slot | output | SLOT_W | Slot of the most recently completed poll |
| err_flag | output | 1 | Bus error flag |
| temp_word | output | DATA_W | Last successfully read word |

## Verification
The bench builds the block with its default parameters: eight slots, 8-bit divider and rate fields, 16-bit data, and pointer reuse allowed. The divider and rate are set at run time to values from zero to two. This keeps intervals to a few cycles, so hundreds of polls fit in a short run and exact interval counts can be checked. With all eight slots, the wrap from slot 7 to slot 0 and sparse presence masks of every shape come up under random presence. Because pointer reuse is allowed, both pointer styles can be reached.

// File: rtl/dts_autopoll_pkg.sv
package dts_autopoll_pkg;
   // Sequencer state: idle, request pending grant, granted poll in flight
   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_REQ  = 2'd1,
      PS_WAIT = 2'd2
   } poll_state_e;
endpackage

// File: rtl/dts_interval_timer.sv
// Two-stage interval timer: a shared prescaler and a per-channel tick count.
module dts_interval_timer #(
   parameter int DIV_W  = 8,
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic [DIV_W-1:0]  base_div,
   input  logic [RATE_W-1:0] poll_rate,
   output logic              due
);
   logic [DIV_W-1:0]  pre_q;
   logic [RATE_W-1:0] tick_q;
   logic              due_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         tick_q <= '0;
         due_q  <= 1'b0;
      end else if (!run_en) begin
         pre_q  <= '0;
         tick_q <= '0;
         due_q  <= 1'b0;
      end else if (!due_q) begin
         if (pre_q >= base_div) begin
            pre_q <= '0;
            if (tick_q >= poll_rate) begin
               tick_q <= '0;
               due_q  <= 1'b1;
            end else begin
               tick_q <= tick_q + 1'b1;
            end
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

   assign due = due_q;
endmodule

// File: rtl/dts_slot_pick.sv
// Round-robin pick of the next present slot after the last visited one.
module dts_slot_pick #(
   parameter int NSLOT  = 8,
   parameter int SLOT_W = 3
) (
   input  logic [NSLOT-1:0]  present,
   input  logic [SLOT_W-1:0] last_slot,
   output logic [SLOT_W-1:0] pick,
   output logic              any_present
);
   logic [SLOT_W-1:0] cand [NSLOT];
   logic [NSLOT-1:0]  hit;

   // cand[k] is the slot k+1 positions after last_slot, circularly
   for (genvar k = 0; k < NSLOT; k++) begin : g_cand
      logic [SLOT_W:0] sum;
      assign sum     = {1'b0, last_slot} + (SLOT_W+1)'(k + 1);
      assign cand[k] = (sum >= (SLOT_W+1)'(NSLOT)) ? SLOT_W'(sum - (SLOT_W+1)'(NSLOT))
                                                    : SLOT_W'(sum);
      assign hit[k]  = present[cand[k]];
   end

   always_comb begin
      pick = last_slot;
      for (int k = NSLOT - 1; k >= 0; k--) begin
         if (hit[k]) pick = cand[k];
      end
   end

   assign any_present = |present;
endmodule

// File: rtl/dts_poll_status.sv
// Status fields written by the poller: last slot, error flag, read word.
module dts_poll_status #(
   parameter int SLOT_W = 3,
   parameter int DATA_W = 16,
   parameter int INIT_SLOT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              poll_done,
   input  logic              poll_nack,
   input  logic [SLOT_W-1:0] poll_slot,
   input  logic [DATA_W-1:0] poll_data,
   input  logic              sw_nack,
   input  logic              err_clr,
   output logic [SLOT_W-1:0] last_slot,
   output logic              err_flag,
   output logic [DATA_W-1:0] temp_word
);
   logic [SLOT_W-1:0] last_q;
   logic              err_q;
   logic [DATA_W-1:0] word_q;
   logic              err_set;

   assign err_set = (poll_done && poll_nack) || sw_nack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= SLOT_W'(INIT_SLOT);
         err_q  <= 1'b0;
         word_q <= '0;
      end else begin
         if (poll_done) last_q <= poll_slot;
         if (poll_done && !poll_nack) word_q <= poll_data;
         if (err_set)      err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
      end
   end

   assign last_slot = last_q;
   assign err_flag  = err_q;
   assign temp_word = word_q;
endmodule

// File: rtl/dts_autopoll.sv
module dts_autopoll
   import dts_autopoll_pkg::*;
#(
   parameter int NSLOT        = 8,
   parameter int DIV_W        = 8,
   parameter int RATE_W       = 8,
   parameter int DATA_W       = 16,
   parameter bit PTR_REUSE_OK = 1'b1,
   localparam int SLOT_W      = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              poll_en,
   input  logic [NSLOT-1:0]  slot_present,
   input  logic              reuse_ptr,
   input  logic [DIV_W-1:0]  base_div,
   input  logic [RATE_W-1:0] poll_rate,
   input  logic              sw_nack,
   input  logic              err_clr,
   output logic              eng_req,
   output logic [SLOT_W-1:0] eng_slot,
   output logic              eng_ptr_wr,
   input  logic              eng_grant,
   input  logic              eng_done,
   input  logic              eng_nack,
   input  logic [DATA_W-1:0] eng_rdata,
   output logic              busy,
   output logic [SLOT_W-1:0] last_slot,
   output logic              err_flag,
   output logic [DATA_W-1:0] temp_word
);
   // Elaboration-time parameter checks
   if (NSLOT < 2) begin : g_bad_nslot
      $error("dts_autopoll: NSLOT must be at least 2");
   end
   if (DIV_W < 1 || RATE_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("dts_autopoll: widths must be positive");
   end

   poll_state_e       state_q;
   logic [SLOT_W-1:0] cur_slot_q;
   logic              cur_ptr_q;
   logic              due;
   logic              any_present;
   logic [SLOT_W-1:0] next_slot;
   logic              ptr_sel;
   logic              launch;
   logic              poll_done;

   // Pointer style: honour the software choice, or always rewrite
   if (PTR_REUSE_OK) begin : g_ptr_sel
      assign ptr_sel = !reuse_ptr;
   end else begin : g_ptr_fixed
      logic unused_reuse;
      assign unused_reuse = reuse_ptr;
      assign ptr_sel      = 1'b1;
   end

   dts_interval_timer #(
      .DIV_W  (DIV_W),
      .RATE_W (RATE_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (poll_en && (state_q == PS_IDLE)),
      .base_div  (base_div),
      .poll_rate (poll_rate),
      .due       (due)
   );

   dts_slot_pick #(
      .NSLOT  (NSLOT),
      .SLOT_W (SLOT_W)
   ) u_pick (
      .present     (slot_present),
      .last_slot   (last_slot),
      .pick        (next_slot),
      .any_present (any_present)
   );

   assign launch    = (state_q == PS_IDLE) && poll_en && due && !err_flag && any_present;
   assign poll_done = (state_q == PS_WAIT) && eng_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PS_IDLE;
         cur_slot_q <= '0;
         cur_ptr_q  <= 1'b1;
      end else begin
         unique case (state_q)
            PS_IDLE: begin
               if (launch) begin
                  state_q    <= PS_REQ;
                  cur_slot_q <= next_slot;
                  cur_ptr_q  <= ptr_sel;
               end
            end
            PS_REQ: begin
               if (eng_grant)     state_q <= PS_WAIT;
               else if (!poll_en) state_q <= PS_IDLE;
            end
            PS_WAIT: begin
               if (eng_done) state_q <= PS_IDLE;
            end
            default: state_q <= PS_IDLE;
         endcase
      end
   end

   dts_poll_status #(
      .SLOT_W    (SLOT_W),
      .DATA_W    (DATA_W),
      .INIT_SLOT (NSLOT - 1)
   ) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .poll_done (poll_done),
      .poll_nack (eng_nack),
      .poll_slot (cur_slot_q),
      .poll_data (eng_rdata),
      .sw_nack   (sw_nack),
      .err_clr   (err_clr),
      .last_slot (last_slot),
      .err_flag  (err_flag),
      .temp_word (temp_word)
   );

   assign eng_req    = (state_q == PS_REQ);
   assign eng_slot   = cur_slot_q;
   assign eng_ptr_wr = cur_ptr_q;
   assign busy       = (state_q != PS_IDLE);
endmodule

// File: rtl/dts_autopoll_chk.sv
module dts_autopoll_chk #(
   parameter int NSLOT  = 8,
   parameter int SLOT_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              poll_en,
   input logic [NSLOT-1:0]  slot_present,
   input logic              eng_req,
   input logic [SLOT_W-1:0] eng_slot,
   input logic              eng_ptr_wr,
   input logic              eng_grant,
   input logic              eng_done,
   input logic              busy,
   input logic [SLOT_W-1:0] last_slot,
   input logic              err_flag
);
   // R4
   no_launch_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_req) |-> !$past(err_flag));

   // R5
   no_launch_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_req) |-> $past(poll_en));

   // R5
   req_withdrawn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !poll_en) |=> !eng_req);

   // R3
   present_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_req) |-> ((($past(slot_present) >> eng_slot) & NSLOT'(1)) != '0));

   // R6
   granted_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_grant) |=> busy);

   // R6
   inflight_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !eng_req && !eng_done) |=> busy);

   // R7
   last_slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_done |=> $stable(last_slot));

   // R9
   cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(eng_ptr_wr) && $stable(eng_slot)));
endmodule

bind dts_autopoll dts_autopoll_chk #(
   .NSLOT  (NSLOT),
   .SLOT_W (SLOT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .poll_en      (poll_en),
   .slot_present (slot_present),
   .eng_req      (eng_req),
   .eng_slot     (eng_slot),
   .eng_ptr_wr   (eng_ptr_wr),
   .eng_grant    (eng_grant),
   .eng_done     (eng_done),
   .busy         (busy),
   .last_slot    (last_slot),
   .err_flag     (err_flag)
);

// File: tb/dts_autopoll_bench.sv
module dts_autopoll_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NSLOT  = 8;
   localparam int SLOT_W = 3;
   localparam int DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              poll_en = 1'b0;
   logic [NSLOT-1:0]  slot_present = '0;
   logic              reuse_ptr = 1'b0;
   logic [7:0]        base_div = '0;
   logic [7:0]        poll_rate = '0;
   logic              sw_nack = 1'b0;
   logic              err_clr = 1'b0;
   logic              eng_req;
   logic [SLOT_W-1:0] eng_slot;
   logic              eng_ptr_wr;
   logic              eng_grant = 1'b0;
   logic              eng_done = 1'b0;
   logic              eng_nack = 1'b0;
   logic [DATA_W-1:0] eng_rdata = '0;
   logic              busy;
   logic [SLOT_W-1:0] last_slot;
   logic              err_flag;
   logic [DATA_W-1:0] temp_word;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit finished = 1'b0;
   int exp_last = NSLOT - 1;
   logic [DATA_W-1:0] exp_word = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dts_autopoll u_dts_autopoll (
      .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .slot_present(slot_present),
      .reuse_ptr(reuse_ptr), .base_div(base_div), .poll_rate(poll_rate),
      .sw_nack(sw_nack), .err_clr(err_clr), .eng_req(eng_req), .eng_slot(eng_slot),
      .eng_ptr_wr(eng_ptr_wr), .eng_grant(eng_grant), .eng_done(eng_done),
      .eng_nack(eng_nack), .eng_rdata(eng_rdata), .busy(busy), .last_slot(last_slot),
      .err_flag(err_flag), .temp_word(temp_word)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Reference: first present slot after 'last', ascending with wrap
   function automatic int ref_next(input int last, input logic [NSLOT-1:0] pres);
      for (int i = 1; i <= NSLOT; i++) begin
         if (pres[(last + i) % NSLOT]) return (last + i) % NSLOT;
      end
      return -1;
   endfunction

   // Wait for eng_req; returns the number of edges waited, or limit+1
   task automatic wait_req(input int limit, output int cnt);
      cnt = 0;
      while (cnt <= limit) begin
         @(negedge clk);
         cnt++;
         if (eng_req) return;
      end
   endtask

   task automatic count_req(input int n, output int seen);
      seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (eng_req) seen++;
      end
   endtask

   // Grant a visible request and finish it
   task automatic serve(input int gdly, input int ddly, input bit nack, input logic [DATA_W-1:0] data);
      int slot_seen;
      slot_seen = int'(eng_slot);
      for (int i = 0; i < gdly; i++) begin
         @(negedge clk);
         chk(eng_req == 1'b1, "R6 request held until grant", eng_req, 1);
      end
      eng_grant = 1'b1;
      @(negedge clk);
      eng_grant = 1'b0;
      chk(busy == 1'b1 && eng_req == 1'b0, "R6 busy after grant", busy, 1);
      for (int i = 0; i < ddly; i++) begin
         @(negedge clk);
         chk(busy == 1'b1, "R6 busy while in flight", busy, 1);
      end
      eng_done = 1'b1; eng_nack = nack; eng_rdata = data;
      @(negedge clk);
      eng_done = 1'b0; eng_nack = 1'b0;
      chk(busy == 1'b0, "R6 busy clears after done", busy, 0);
      chk(int'(last_slot) == slot_seen, "R7 last slot updated", last_slot, slot_seen);
      exp_last = slot_seen;
      if (!nack) exp_word = data;
      chk(temp_word == exp_word, "R10 captured word", temp_word, exp_word);
      chk(err_flag == nack, "R8 error after poll", err_flag, nack);
   endtask

   task automatic check_launch(input string tag);
      int es;
      es = ref_next(exp_last, slot_present);
      chk(int'(eng_slot) == es, tag, eng_slot, es);
      chk(eng_ptr_wr == !reuse_ptr, "R9 pointer style", eng_ptr_wr, !reuse_ptr);
   endtask

   initial begin : watchdog
      while (!finished) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin : stim
      int cnt;
      int seen;
      int dummy;
      dummy = $urandom(20240611);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 1'b0 && eng_req == 1'b0, "R1 idle at reset", busy, 0);
      chk(err_flag == 1'b0, "R1 error clear at reset", err_flag, 0);
      chk(int'(last_slot) == NSLOT - 1, "R1 last slot at reset", last_slot, NSLOT - 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 interval and R3 first slot
      slot_present = 8'b1010_0100; base_div = 8'd1; poll_rate = 8'd2; reuse_ptr = 1'b0;
      poll_en = 1'b1;
      wait_req(100, cnt);
      chk(cnt == 7, "R2 first interval", cnt, 7);
      check_launch("R3 first present slot");
      serve(1, 2, 1'b0, 16'h1234);
      wait_req(100, cnt);
      chk(cnt == 7, "R2 interval after completion", cnt, 7);
      check_launch("R3 ascending order");
      serve(0, 0, 1'b0, 16'h2345);
      wait_req(100, cnt);
      check_launch("R3 skip absent slot");
      serve(0, 1, 1'b0, 16'h3456);
      wait_req(100, cnt);
      check_launch("R3 wrap to lowest");
      serve(0, 0, 1'b0, 16'h4567);

      // R5 withdraw before grant, then R11 resume
      wait_req(100, cnt);
      poll_en = 1'b0;
      @(negedge clk);
      chk(eng_req == 1'b0 && busy == 1'b0, "R5 request withdrawn", eng_req, 0);
      chk(int'(last_slot) == exp_last, "R7 last slot kept on withdraw", last_slot, exp_last);
      repeat (3) @(negedge clk);
      base_div = 8'd0; poll_rate = 8'd3; poll_en = 1'b1;
      wait_req(100, cnt);
      chk(cnt == 5, "R11 timer restarts on re-enable", cnt, 5);
      check_launch("R11 resume after last slot");

      // R6 handoff: drop enable while the poll is in flight
      eng_grant = 1'b1;
      @(negedge clk);
      eng_grant = 1'b0; poll_en = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk(busy == 1'b1, "R6 in-flight poll completes after disable", busy, 1);
      end
      eng_done = 1'b1; eng_rdata = 16'h5a5a;
      @(negedge clk);
      eng_done = 1'b0;
      exp_last = int'(eng_slot); exp_word = 16'h5a5a;
      chk(busy == 1'b0, "R6 busy drops for handoff", busy, 0);
      count_req(40, seen);
      chk(seen == 0, "R5 no request while disabled", seen, 0);

      // R4 error gating, R8 set/clear priority
      poll_en = 1'b1; base_div = 8'd0; poll_rate = 8'd0;
      sw_nack = 1'b1;
      @(negedge clk);
      sw_nack = 1'b0;
      chk(err_flag == 1'b1, "R8 software NACK sets error", err_flag, 1);
      count_req(30, seen);
      chk(seen == 0, "R4 no poll while error set", seen, 0);
      sw_nack = 1'b1; err_clr = 1'b1;
      @(negedge clk);
      sw_nack = 1'b0; err_clr = 1'b0;
      chk(err_flag == 1'b1, "R8 set wins over clear", err_flag, 1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk(err_flag == 1'b0, "R8 clear", err_flag, 0);
      chk(eng_req == 1'b0, "R4 launch not before second edge", eng_req, 0);
      @(negedge clk);
      chk(eng_req == 1'b1, "R4 pending poll launches after clear", eng_req, 1);
      check_launch("R3 slot after error");
      serve(0, 0, 1'b1, 16'hdead);
      chk(temp_word == exp_word, "R10 NACK keeps word", temp_word, exp_word);
      count_req(20, seen);
      chk(seen == 0, "R4 poll NACK blocks polling", seen, 0);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;

      // R3 no present slot
      slot_present = '0;
      count_req(30, seen);
      chk(seen == 0, "R3 no slot present no poll", seen, 0);

      // Random phase
      for (int it = 0; it < 300; it++) begin
         bit nk;
         slot_present = NSLOT'($urandom_range(1, (1 << NSLOT) - 1));
         reuse_ptr = 1'($urandom_range(0, 1));
         base_div = 8'($urandom_range(0, 2));
         poll_rate = 8'($urandom_range(0, 2));
         wait_req(100, cnt);
         chk(cnt <= 100, "R2 poll arrives", cnt, 100);
         check_launch("R3 random order");
         nk = ($urandom_range(0, 3) == 0);
         serve($urandom_range(0, 2), $urandom_range(0, 3), nk, 16'($urandom));
         if (nk) begin
            err_clr = 1'b1;
            @(negedge clk);
            err_clr = 1'b0;
            chk(err_flag == 1'b0, "R8 clear after poll NACK", err_flag, 0);
         end
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule